// File: doc/BRIEF.md
# Overflow and Fault Flag Sequencer

This block sits between the decimation filters of a four-channel converter and its output port. Each cycle it can take one set of raw channel results, wider than the output word. It limits every result to the signed full-scale range of the output word and passes the set on through a single valid/ready register stage. It also drives two active-low status flags. `fault_n` reports an input overvoltage condition on any channel. `ovrflw_n` reports a clipped result or an active fault.

A channel's fault starts as soon as its comparator reports the condition while protection is enabled. From that cycle the channel's results are pinned at full scale. The sign of that full-scale value is the sign the comparator reported in the last fault cycle. When the condition ends, a per-channel recovery counter runs for `RECOV` output-data periods, counted on `period_tick`. Results stay pinned until the counter reaches zero. A new fault during recovery restarts the counter. `fault_n` stays low while any channel is in fault or in recovery. Setting `fault_dis` turns detection off and cancels any recovery in progress.

Data stream rules: a result set is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or `out_ready` is high. `out_data` is held unchanged while `out_valid` is high and `out_ready` is low. The status flags are plain signals and are not part of the handshake.

Top module: `ovf_fault_seq`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `fault_n` is 1 and `ovrflw_n` is 1.
- R2: An accepted raw result inside the range `FS_NEG..FS_POS` appears unchanged on its channel lane of `out_data` in the cycle after acceptance. Here `FS_POS = 2^(DW-1)-1` and `FS_NEG = -2^(DW-1)`, and channel c occupies bits `[c*DW +: DW]` in two's complement.
- R3: A raw result above `FS_POS` is output as `FS_POS`. A raw result below `FS_NEG` is output as `FS_NEG`.
- R4: `ovrflw_n` is low whenever `fault_n` is low. It is also low while `out_valid` presents a set in which any channel was clipped or held. Otherwise it is high.
- R5: With `fault_dis` = 0, `fault_n` is low in the cycle after any edge that samples a set bit of `over_thr`.
- R6: After the last edge that samples a channel's `over_thr` high, that channel counts `RECOV` edges with `period_tick` high (default 22). `fault_n` rises in the cycle after the final one, provided no channel is still in fault or recovery. An edge that samples `over_thr` high reloads the count, even if `period_tick` is also high on that edge.
- R7: A set accepted while a channel is in fault, or in recovery before its final tick edge, carries full scale on that channel. The value is `FS_NEG` if `over_neg` was 1 on the latest fault edge and `FS_POS` otherwise.
- R8: A fault or clip on one channel leaves the lanes of the other channels unchanged.
- R9: With `fault_dis` = 1, no fault is detected and no result is held; results are only range-clipped. In the cycle after an edge that samples `fault_dis` high, `fault_n` is 1 and any recovery is cancelled.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` is stable. `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_dis | input | 1 | 1 disables fault detection and hold |
| period_tick | input | 1 | One-cycle pulse per output-data period |
| over_thr | input | NCH | Per-channel comparator: input outside fault thresholds |
| over_neg | input | NCH | Per-channel sign of the faulting input, 1 = negative |
| in_valid | input | 1 | Raw result set valid |
| in_ready | output | 1 | Block can accept a result set |
| in_data | input | NCH*RW | Raw signed results, channel c at `[c*RW +: RW]` |
| out_valid | output | 1 | Output result set valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | NCH*DW | Clamped signed results, channel c at `[c*DW +: DW]` |
| fault_n | output | 1 | Active-low fault flag |
| ovrflw_n | output | 1 | Active-low overflow flag |

## Verification
Results and the overflow flag come one register after the accepting edge, so `fault_n` falls one cycle after the fault is sampled. The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore sees exactly the state left by the single rising edge in between. Recovery checks step `period_tick` one edge at a time. They verify that `fault_n` is still low after `RECOV-1` counted ticks and high after the `RECOV`-th. They also verify that a result captured on that final edge is still held and that the next one passes through.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {FS_SIGN_POS = 1'b0, FS_SIGN_NEG = 1'b1} fs_sign_e;
endpackage

// File: rtl/ofs_fault_timer.sv
module ofs_fault_timer #(
  parameter int RECOV = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_dis,
  input  logic tick,
  input  logic over,
  input  logic over_neg,
  output logic hold,
  output logic hold_neg,
  output logic busy
);
  import ofs_pkg::*;
  localparam int CW = $clog2(RECOV + 1);

  logic [CW-1:0] cnt_q;
  fs_sign_e      sign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sign_q <= FS_SIGN_POS;
    end else if (fault_dis) begin
      cnt_q  <= '0;
    end else if (over) begin
      cnt_q  <= CW'(RECOV);
      sign_q <= fs_sign_e'(over_neg);
    end else if (tick && cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy     = (cnt_q != '0);
  assign hold     = !fault_dis && (over || busy);
  assign hold_neg = over ? over_neg : (sign_q == FS_SIGN_NEG);
endmodule

// File: rtl/ofs_clamp.sv
module ofs_clamp #(
  parameter int RW = 26,
  parameter int DW = 24
) (
  input  logic signed [RW-1:0] raw,
  input  logic                 hold,
  input  logic                 hold_neg,
  output logic        [DW-1:0] res,
  output logic                 flag
);
  localparam logic signed [RW-1:0] HI = RW'((2 ** (DW - 1)) - 1);
  localparam logic signed [RW-1:0] LO = RW'(-(2 ** (DW - 1)));

  logic above, below;

  always_comb begin
    above = (raw > HI);
    below = (raw < LO);
    if (hold)       res = hold_neg ? LO[DW-1:0] : HI[DW-1:0];
    else if (above) res = HI[DW-1:0];
    else if (below) res = LO[DW-1:0];
    else            res = raw[DW-1:0];
    flag = hold || above || below;
  end
endmodule

// File: rtl/ovf_fault_seq.sv
module ovf_fault_seq #(
  parameter int NCH   = 4,
  parameter int DW    = 24,
  parameter int RW    = 26,
  parameter int RECOV = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_dis,
  input  logic              period_tick,
  input  logic [NCH-1:0]    over_thr,
  input  logic [NCH-1:0]    over_neg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*RW-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*DW-1:0] out_data,
  output logic              fault_n,
  output logic              ovrflw_n
);
  logic [NCH-1:0]         hold, hold_neg, busy, flag;
  logic [NCH-1:0][DW-1:0] res;
  logic [NCH-1:0][DW-1:0] data_q;
  logic                   valid_q, clip_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ofs_fault_timer #(.RECOV(RECOV)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault_dis(fault_dis),
      .tick     (period_tick),
      .over     (over_thr[c]),
      .over_neg (over_neg[c]),
      .hold     (hold[c]),
      .hold_neg (hold_neg[c]),
      .busy     (busy[c])
    );

    ofs_clamp #(.RW(RW), .DW(DW)) u_clamp (
      .raw     (in_data[c*RW +: RW]),
      .hold    (hold[c]),
      .hold_neg(hold_neg[c]),
      .res     (res[c]),
      .flag    (flag[c])
    );

    assign out_data[c*DW +: DW] = data_q[c];
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      clip_q  <= 1'b0;
      data_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        data_q <= res;
        clip_q <= |flag;
      end
    end
  end

  assign out_valid = valid_q;
  assign fault_n   = ~|busy;
  assign ovrflw_n  = fault_n && !(valid_q && clip_q);
endmodule

// File: rtl/ofs_checker.sv
module ofs_checker #(
  parameter int NCH = 4,
  parameter int DW  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_dis,
  input logic              period_tick,
  input logic [NCH-1:0]    over_thr,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*DW-1:0] out_data,
  input logic              fault_n,
  input logic              ovrflw_n
);
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_fault_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((over_thr != '0) && !fault_dis) |=> !fault_n);

  p_dis_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_dis |=> fault_n);

  p_ovf_with_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !ovrflw_n);

  p_release_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> ($past(period_tick) || $past(fault_dis)));
endmodule

bind ovf_fault_seq ofs_checker #(.NCH(NCH), .DW(DW)) u_ofs_checker (
  .clk(clk), .rst_n(rst_n), .fault_dis(fault_dis), .period_tick(period_tick),
  .over_thr(over_thr), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .fault_n(fault_n),
  .ovrflw_n(ovrflw_n)
);

// File: tb/ovf_fault_seq_bench.sv
`timescale 1ns/1ps
module ovf_fault_seq_bench;
  localparam int NCH = 4, DW = 8, RW = 10, RECOV = 22;
  localparam int HI = 127, LO = -128;

  logic clk = 1'b0, rst_n = 1'b0, fault_dis = 1'b0, period_tick = 1'b0;
  logic [NCH-1:0] over_thr = '0, over_neg = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [NCH*RW-1:0] in_data = '0;
  logic in_ready, out_valid, fault_n, ovrflw_n;
  logic [NCH*DW-1:0] out_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ovf_fault_seq #(.NCH(NCH), .DW(DW), .RW(RW), .RECOV(RECOV)) u_ovf_fault_seq (
    .clk(clk), .rst_n(rst_n), .fault_dis(fault_dis), .period_tick(period_tick),
    .over_thr(over_thr), .over_neg(over_neg), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .fault_n(fault_n),
    .ovrflw_n(ovrflw_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lane(int k);
    logic signed [DW-1:0] v;
    v = out_data[k*DW +: DW];
    return int'(v);
  endfunction

  function automatic int clipv(int v);
    return (v > HI) ? HI : ((v < LO) ? LO : v);
  endfunction

  task automatic set_raw(int a, int b, int c, int d);
    in_data[0*RW +: RW] = RW'(a);
    in_data[1*RW +: RW] = RW'(b);
    in_data[2*RW +: RW] = RW'(c);
    in_data[3*RW +: RW] = RW'(d);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      period_tick = 1'b1; step();
      period_tick = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 fault_n", fault_n, 1);
    check("R1 ovrflw_n", ovrflw_n, 1);

    // R2 R3 R4: sweep of every raw value on each lane
    in_valid = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      int r[NCH];
      int anyclip;
      anyclip = 0;
      for (int k = 0; k < NCH; k++) begin
        r[k] = ((i + k * 301) % 1024) - 512;
        if (clipv(r[k]) != r[k]) anyclip = 1;
      end
      set_raw(r[0], r[1], r[2], r[3]);
      step();
      for (int k = 0; k < NCH; k++)
        check((clipv(r[k]) == r[k]) ? "R2 pass" : "R3 clip", lane(k), clipv(r[k]));
      check("R4 ovrflw_n", ovrflw_n, anyclip ? 0 : 1);
    end

    // R5 R7 R8: negative fault on channel 1
    set_raw(10, 10, 10, 10);
    over_thr = 4'b0010; over_neg = 4'b0010;
    step();
    check("R5 fault_n low", fault_n, 0);
    check("R7 neg hold", lane(1), LO);
    check("R8 ch0 intact", lane(0), 10);
    check("R8 ch3 intact", lane(3), 10);
    check("R4 ovf with fault", ovrflw_n, 0);
    over_thr = '0; over_neg = '0;
    ticks(RECOV - 1);
    check("R6 still low", fault_n, 0);
    check("R7 sign kept", lane(1), LO);
    ticks(1);
    check("R6 release", fault_n, 1);
    check("R7 last edge held", lane(1), LO);
    step();
    check("R7 unheld", lane(1), 10);
    check("R4 ovf clear", ovrflw_n, 1);

    // R6 reload: positive fault on channel 2 re-entered with a tick
    over_thr = 4'b0100; step();
    over_thr = '0; ticks(10);
    over_thr = 4'b0100; ticks(1);
    over_thr = '0;
    ticks(RECOV - 1);
    check("R6 reload low", fault_n, 0);
    check("R7 pos hold", lane(2), HI);
    ticks(1);
    check("R6 reload release", fault_n, 1);

    // R9: disabled detection
    set_raw(5, 5, 5, 5);
    fault_dis = 1'b1; over_thr = 4'b0001;
    step();
    check("R9 no fault", fault_n, 1);
    check("R9 no hold", lane(0), 5);
    check("R9 ovf high", ovrflw_n, 1);
    fault_dis = 1'b0; step();
    check("R5 fault_n ch0", fault_n, 0);
    over_thr = '0; step();
    fault_dis = 1'b1; step();
    check("R9 cancel", fault_n, 1);
    check("R9 cancel data", lane(0), 5);
    fault_dis = 1'b0; step();
    check("R9 stays clear", fault_n, 1);

    // R10: back-pressure
    out_ready = 1'b0; set_raw(1, 2, 3, 4);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R10 in_ready", in_ready, 0);
      check("R10 stable", lane(0), 5);
    end
    out_ready = 1'b1; step();
    check("R10 resume", lane(3), 4);
    check("R10 ready", in_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule